// File: doc/BRIEF.md
# Switchable Domain Power Sequencer

This controller sits in the always-on clock domain and decides when a second, switchable logic domain may carry traffic, must sit in reset, or may lose its supply. The two domains exchange data through handshaked crossings, and each crossing holds at most one transfer at a time. Because of that, a single busy flag from the crossing logic tells the sequencer when traffic has fully drained.

A switch-off request first withdraws the traffic permit, then waits for the busy flag to clear. It then drives reset into the switchable domain and removes the supply only once that reset is seen to have arrived. A switch-on request restores the supply with reset still held. It waits for the power-good input to stay high for a set number of consecutive cycles, releases reset through a two-flop synchronizer clocked by the switchable domain's clock, and grants the permit again only after the release has been seen to take effect.

A request for the opposite direction that arrives while a sequence is running is kept. It is acted on when the sequence reaches its settled end state.

Top module: `pwrseq_top`

## Requirements
- R1: During and after reset the block is in the OFF state (state code 4), with pwr_en low, sw_rst high, allow low, seq_done high and done_pulse low.
- R2: A switch-off request in the ON state (code 0) moves the block, at the next clock edge, to GATING (code 1). In GATING allow is low while pwr_en stays high and sw_rst stays low.
- R3: After GATING the block waits in DRAINING (code 2), with power on and reset released, for as long as busy is high. It moves to RESETTING (code 3) at the first edge that sees busy low.
- R4: pwr_en goes low only after sw_rst has gone high, and whenever pwr_en is low sw_rst is high.
- R5: A switch-on request in OFF moves the block at the next edge to POWERING (code 5), with pwr_en high and sw_rst still high. The block leaves POWERING for RELEASING (code 6) only after pwr_good has been high on PG_CYCLES consecutive edges while in POWERING.
- R6: allow is high only in the ON state, and only while pwr_en is high and sw_rst is low. The block enters ON through ENABLING (code 7) only after the release of reset has been seen to take effect.
- R7: A change of the internal reset request reaches sw_rst on the second rising edge of sw_clk after the change.
- R8: A switch-on request made during a power-down, or a switch-off request made during a power-up, is held. It starts the opposite sequence from the OFF or ON state without being repeated.
- R9: In the ON state the busy input and further switch-on requests have no effect: the state stays ON, allow stays high and sw_rst stays low.
- R10: done_pulse is high for exactly one cycle on each entry to ON or OFF. seq_done is high exactly when the state is ON or OFF.
- R11: A low cycle on pwr_good during POWERING restarts the consecutive count needed in R5.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_clk | input | 1 | Clock of the switchable domain, used by the reset synchronizer |
| req_on | input | 1 | Request to power the switchable domain up (one-cycle pulse) |
| req_off | input | 1 | Request to power the switchable domain down (one-cycle pulse) |
| busy | input | 1 | High while a crossing holds a transfer in flight |
| pwr_good | input | 1 | Supply of the switchable domain is within limits |
| pwr_en | output | 1 | Enables the supply of the switchable domain |
| sw_rst | output | 1 | Reset into the switchable domain, synchronous to sw_clk |
| allow | output | 1 | Permits new traffic from the always-on side |
| seq_done | output | 1 | High when no sequence is in progress |
| done_pulse | output | 1 | One-cycle pulse on reaching ON or OFF |
| state_o | output | 3 | Current sequencer state code |

## Verification
Some rules are checked on every cycle by properties: allow is only granted into a powered domain that is out of reset, the supply is never off unless reset is held, DRAINING is held while busy is high, done_pulse lasts one cycle, and power-good has been seen before reset is released. Other behaviour only the directed scenarios can show. These are the exact count of power-good cycles, including the restart after a glitch, and the two sw_clk edges of synchronizer latency in each direction. They also cover held requests that turn a finished sequence around, and the ignored inputs in the ON state.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_ON      = 3'd0,
        ST_GATE    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_RESET   = 3'd3,
        ST_OFF     = 3'd4,
        ST_POWER   = 3'd5,
        ST_RELEASE = 3'd6,
        ST_ENABLE  = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic pwr_en;
        logic rst_req;
        logic allow;
    } seq_out_t;

    // Output levels held in each state
    function automatic seq_out_t outputs_for(seq_state_e s);
        seq_out_t o;
        o.pwr_en  = (s != ST_OFF);
        o.rst_req = (s == ST_RESET) || (s == ST_OFF) || (s == ST_POWER);
        o.allow   = (s == ST_ON);
        return o;
    endfunction

    // States that belong to the power-up direction
    function automatic logic is_up_dir(seq_state_e s);
        return (s == ST_POWER) || (s == ST_RELEASE) ||
               (s == ST_ENABLE) || (s == ST_ON);
    endfunction

    function automatic logic is_settled(seq_state_e s);
        return (s == ST_ON) || (s == ST_OFF);
    endfunction

endpackage

// File: rtl/pwrseq_pend.sv
// Holds a direction request until the sequencer can act on it.
module pwrseq_pend (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic set_req,
    input  logic clr_req,
    input  logic take,
    output logic go
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (take) begin
            pend_q <= 1'b0;
        end else if (accept && set_req) begin
            pend_q <= 1'b1;
        end else if (accept && clr_req) begin
            pend_q <= 1'b0;
        end
    end

    assign go = pend_q || (accept && set_req);
endmodule

// File: rtl/pwrseq_pg_filter.sv
// Counts consecutive power-good cycles while enabled.
module pwrseq_pg_filter #(
    parameter int PG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic pwr_good,
    output logic stable
);
    localparam int CW = $clog2(PG_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PG_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable || !pwr_good) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = (cnt_q == LIMIT);
endmodule

// File: rtl/pwrseq_rst_sync.sv
// Carries the reset request into the switchable domain and
// reports its arrival back into the always-on domain.
module pwrseq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_clk,
    input  logic rst_req,
    output logic sw_rst,
    output logic rst_ack
);
    logic [STAGES-1:0] fwd_q;
    logic [STAGES-1:0] back_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            logic fwd_in;
            logic back_in;
            if (i == 0) begin : g_first
                assign fwd_in  = rst_req;
                assign back_in = fwd_q[STAGES-1];
            end else begin : g_next
                assign fwd_in  = fwd_q[i-1];
                assign back_in = back_q[i-1];
            end

            always_ff @(posedge sw_clk) begin
                if (rst) fwd_q[i] <= 1'b1;
                else     fwd_q[i] <= fwd_in;
            end

            always_ff @(posedge clk) begin
                if (rst) back_q[i] <= 1'b1;
                else     back_q[i] <= back_in;
            end
        end
    endgenerate

    assign sw_rst  = fwd_q[STAGES-1];
    assign rst_ack = back_q[STAGES-1];
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       on_go,
    input  logic       off_go,
    input  logic       busy,
    input  logic       pg_stable,
    input  logic       rst_ack,
    output seq_state_e state_q,
    output logic       up_dir,
    output logic       take_on,
    output logic       take_off,
    output logic       pg_enable,
    output logic       pwr_en,
    output logic       rst_req,
    output logic       allow,
    output logic       seq_done,
    output logic       done_pulse
);
    seq_state_e state_d;
    seq_out_t   out_d;
    seq_out_t   out_rst;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON:      if (off_go)    state_d = ST_GATE;
            ST_GATE:                   state_d = ST_DRAIN;
            ST_DRAIN:   if (!busy)     state_d = ST_RESET;
            ST_RESET:   if (rst_ack)   state_d = ST_OFF;
            ST_OFF:     if (on_go)     state_d = ST_POWER;
            ST_POWER:   if (pg_stable) state_d = ST_RELEASE;
            ST_RELEASE: if (!rst_ack)  state_d = ST_ENABLE;
            ST_ENABLE:                 state_d = ST_ON;
            default:                   state_d = ST_OFF;
        endcase
    end

    assign take_on   = (state_q == ST_OFF) && on_go;
    assign take_off  = (state_q == ST_ON) && off_go;
    assign up_dir    = is_up_dir(state_q);
    assign pg_enable = (state_q == ST_POWER);
    assign out_d     = outputs_for(state_d);
    assign out_rst   = outputs_for(ST_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            pwr_en     <= out_rst.pwr_en;
            rst_req    <= out_rst.rst_req;
            allow      <= out_rst.allow;
            seq_done   <= 1'b1;
            done_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            pwr_en     <= out_d.pwr_en;
            rst_req    <= out_d.rst_req;
            allow      <= out_d.allow;
            seq_done   <= is_settled(state_d);
            done_pulse <= is_settled(state_d) && (state_d != state_q);
        end
    end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
    parameter int PG_CYCLES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_clk,
    input  logic       req_on,
    input  logic       req_off,
    input  logic       busy,
    input  logic       pwr_good,
    output logic       pwr_en,
    output logic       sw_rst,
    output logic       allow,
    output logic       seq_done,
    output logic       done_pulse,
    output logic [2:0] state_o
);
    import pwrseq_pkg::*;

    seq_state_e state_q;
    logic up_dir, take_on, take_off, on_go, off_go;
    logic pg_enable, pg_stable, rst_req, rst_ack;

    pwrseq_pend u_pend_on (
        .clk(clk), .rst(rst), .accept(!up_dir),
        .set_req(req_on), .clr_req(req_off), .take(take_on), .go(on_go)
    );

    pwrseq_pend u_pend_off (
        .clk(clk), .rst(rst), .accept(up_dir),
        .set_req(req_off), .clr_req(req_on), .take(take_off), .go(off_go)
    );

    pwrseq_pg_filter #(.PG_CYCLES(PG_CYCLES)) u_pg (
        .clk(clk), .rst(rst), .enable(pg_enable),
        .pwr_good(pwr_good), .stable(pg_stable)
    );

    pwrseq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sw_clk(sw_clk), .rst_req(rst_req),
        .sw_rst(sw_rst), .rst_ack(rst_ack)
    );

    pwrseq_fsm u_fsm (
        .clk(clk), .rst(rst), .on_go(on_go), .off_go(off_go),
        .busy(busy), .pg_stable(pg_stable), .rst_ack(rst_ack),
        .state_q(state_q), .up_dir(up_dir), .take_on(take_on),
        .take_off(take_off), .pg_enable(pg_enable), .pwr_en(pwr_en),
        .rst_req(rst_req), .allow(allow), .seq_done(seq_done),
        .done_pulse(done_pulse)
    );

    assign state_o = state_q;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
    import pwrseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       pwr_good,
    input logic       pwr_en,
    input logic       sw_rst,
    input logic       allow,
    input logic       seq_done,
    input logic       done_pulse,
    input logic [2:0] state_o
);
    p_gate_first_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(allow) |-> (pwr_en && !sw_rst));

    p_drain_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DRAIN && busy) |=> (state_o == ST_DRAIN));

    p_off_under_reset_r4: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> sw_rst);

    p_power_under_reset_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_POWER) |-> (pwr_en && sw_rst));

    p_pg_seen_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RELEASE && $past(state_o) == ST_POWER) |-> $past(pwr_good));

    p_allow_live_r6: assert property (@(posedge clk) disable iff (rst)
        allow |-> (pwr_en && !sw_rst && state_o == ST_ON));

    p_on_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_ON) |-> (!sw_rst && allow));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    p_done_settled_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> seq_done);
endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .pwr_good(pwr_good),
    .pwr_en(pwr_en), .sw_rst(sw_rst), .allow(allow),
    .seq_done(seq_done), .done_pulse(done_pulse), .state_o(state_o)
);

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/100ps
module tb_pwrseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int PG = 8;
    localparam logic [2:0] S_ON = 3'd0, S_GATE = 3'd1, S_DRAIN = 3'd2,
        S_RESET = 3'd3, S_OFF = 3'd4, S_POWER = 3'd5, S_RELEASE = 3'd6;

    logic clk = 1'b0, sw_clk = 1'b0, rst = 1'b1;
    logic req_on = 1'b0, req_off = 1'b0, busy = 1'b0, pwr_good = 1'b0;
    logic pwr_en, sw_rst, allow, seq_done, done_pulse;
    logic [2:0] state_o;

    int checks = 0, errors = 0, ord_err = 0;
    int up_cnt = 0, dn_cnt = 0;
    bit up_done = 1'b0, dn_done = 1'b0;
    logic prev_pwr_en = 1'b0, prev_sw_rst = 1'b1;

    pwrseq_top #(.PG_CYCLES(PG), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .sw_clk(sw_clk), .req_on(req_on),
        .req_off(req_off), .busy(busy), .pwr_good(pwr_good),
        .pwr_en(pwr_en), .sw_rst(sw_rst), .allow(allow),
        .seq_done(seq_done), .done_pulse(done_pulse), .state_o(state_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #2.3;
        forever begin sw_clk = 1'b1; #7; sw_clk = 1'b0; #7; end
    end

    // sw_clk edges between a reset-request change and its arrival (R7)
    always @(posedge sw_clk) begin
        logic [2:0] st;
        st = state_o;
        #1;
        case (st)
            S_OFF, S_POWER: begin up_cnt = 0; up_done = 1'b0; end
            S_RELEASE: if (!up_done) begin up_cnt++; if (!sw_rst) up_done = 1'b1; end
            S_ON, S_GATE, S_DRAIN: begin dn_cnt = 0; dn_done = 1'b0; end
            S_RESET: if (!dn_done) begin dn_cnt++; if (sw_rst) dn_done = 1'b1; end
            default: ;
        endcase
    end

    // Ordering monitor for R4 and R6
    always @(negedge clk) begin
        if (!rst) begin
            if (allow && (sw_rst || !pwr_en)) ord_err++;
            if (prev_pwr_en && !pwr_en && !prev_sw_rst) ord_err++;
        end
        prev_pwr_en = pwr_en;
        prev_sw_rst = sw_rst;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wait_state(input logic [2:0] s, input int maxc, input string req);
        int n = 0;
        while (state_o != s && n < maxc) begin @(negedge clk); n++; end
        check(state_o == s, req, state_o, s);
    endtask

    task automatic pulse_on();
        req_on = 1'b1; @(negedge clk); req_on = 1'b0;
    endtask

    task automatic pulse_off();
        req_off = 1'b1; @(negedge clk); req_off = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(state_o == S_OFF, "R1 state", state_o, S_OFF);
        rst = 1'b0;
        @(negedge clk);
        check(state_o == S_OFF, "R1 state after reset", state_o, S_OFF);
        check(!pwr_en && sw_rst && !allow, "R1 outputs", {pwr_en, sw_rst, allow}, 3'b010);
        check(seq_done && !done_pulse, "R1 status", {seq_done, done_pulse}, 2'b10);
    endtask

    task automatic t_power_up();
        int j;
        pwr_good = 1'b0;
        pulse_on();
        check(state_o == S_POWER, "R5 enter POWERING", state_o, S_POWER);
        check(pwr_en && sw_rst, "R5 power on under reset", {pwr_en, sw_rst}, 2'b11);
        check(!seq_done, "R10 seq_done low in sequence", seq_done, 0);
        repeat (4) @(negedge clk);
        check(state_o == S_POWER, "R5 wait for power-good", state_o, S_POWER);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        j = 0;
        do begin @(negedge clk); j++; end while (state_o != S_RELEASE && j < 50);
        check(j == PG + 1, "R11 glitch restarts count", j, PG + 1);
        check(sw_rst, "R5 reset held at release start", sw_rst, 1);
        wait_state(S_ON, 40, "R6 reach ON");
        check(allow && !sw_rst && pwr_en, "R6 allow after release", {allow, sw_rst, pwr_en}, 3'b101);
        check(done_pulse, "R10 done pulse on ON", done_pulse, 1);
        @(negedge clk);
        check(!done_pulse && seq_done, "R10 single pulse", {done_pulse, seq_done}, 2'b01);
        check(up_cnt == 2, "R7 release latency", up_cnt, 2);
    endtask

    task automatic t_on_ignores();
        busy = 1'b1;
        pulse_on();
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
        busy = 1'b1;
        repeat (4) @(negedge clk);
        check(state_o == S_ON, "R9 state stays ON", state_o, S_ON);
        check(allow && !sw_rst, "R9 no reset in ON", {allow, sw_rst}, 2'b10);
    endtask

    task automatic t_power_down();
        busy = 1'b1;
        pulse_off();
        check(state_o == S_GATE, "R2 enter GATING", state_o, S_GATE);
        check(!allow && pwr_en && !sw_rst, "R2 allow lowered first", {allow, pwr_en, sw_rst}, 3'b010);
        @(negedge clk);
        check(state_o == S_DRAIN, "R3 enter DRAINING", state_o, S_DRAIN);
        repeat (6) @(negedge clk);
        check(state_o == S_DRAIN && pwr_en && !sw_rst, "R3 hold while busy",
              {state_o, pwr_en, sw_rst}, {S_DRAIN, 2'b10});
        busy = 1'b0;
        @(negedge clk);
        check(state_o == S_RESET, "R3 leave on busy low", state_o, S_RESET);
        wait_state(S_OFF, 40, "R4 reach OFF");
        check(!pwr_en && sw_rst, "R4 off under reset", {pwr_en, sw_rst}, 2'b01);
        check(done_pulse, "R10 done pulse on OFF", done_pulse, 1);
        check(dn_cnt == 2, "R7 assert latency", dn_cnt, 2);
    endtask

    task automatic t_pend_on();
        pwr_good = 1'b1;
        pulse_on();
        wait_state(S_ON, 60, "R8 power up");
        busy = 1'b1;
        pulse_off();
        wait_state(S_DRAIN, 5, "R8 draining");
        pulse_on();
        repeat (3) @(negedge clk);
        busy = 1'b0;
        wait_state(S_OFF, 40, "R8 reach OFF");
        @(negedge clk);
        check(state_o == S_POWER, "R8 held on-request", state_o, S_POWER);
        wait_state(S_ON, 60, "R8 back ON");
    endtask

    task automatic t_pend_off();
        pulse_off();
        wait_state(S_OFF, 40, "R8 down first");
        pwr_good = 1'b0;
        pulse_on();
        check(state_o == S_POWER, "R8 powering", state_o, S_POWER);
        pulse_off();
        pwr_good = 1'b1;
        wait_state(S_ON, 60, "R8 reach ON");
        @(negedge clk);
        check(state_o == S_GATE, "R8 held off-request", state_o, S_GATE);
        wait_state(S_OFF, 40, "R8 final OFF");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_power_up();
        t_on_ignores();
        t_power_down();
        t_pend_on();
        t_pend_off();
        check(ord_err == 0, "R4 R6 ordering monitor", ord_err, 0);
        finish_run();
    end
endmodule